// File: doc/BRIEF.md
# Stuck-At Fault Coverage Engine

This block measures how well a stimulus sequence exposes single stuck-at faults in a small loadable up/down counter. It holds two copies of the counter. One copy is fault-free. In the other copy, every bit of every port passes through a forceable buffer. For each fault under trial, the engine resets both copies, replays the same stimulus into both, and compares their count outputs on every step. The fault is marked detected if the outputs differ in any step.

The caller supplies the stimulus. On each step the engine presents a step index, and the caller returns the load, up, clear and data values for that step. A start pulse launches a run. In sweep mode the run covers every fault in the list. In single mode it tries one selected fault. When the run ends, `done_o` rises and the detected and total counts hold. Coverage is the detected count divided by the total count.

Top module: `fault_cov_engine`

## Requirements
- R1: Each counter copy has the following priority order. An active-low clear forces the count to zero, including the visible output in the same step, whether or not the copy is being clocked. Below clear, load takes the data input. Otherwise the count increments when up is 1 and decrements when up is 0, wrapping modulo 2^(CW_P+1).
- R2: The count and data buses are CW_P+1 bits wide (4 bits by default).
- R3: A 5-bit fault code is formed as site*2 + polarity, where polarity 0 means stuck-at-0 and polarity 1 means stuck-at-1. The sites are:
  - site 0 is load
  - site 1 is up
  - site 2 is clear
  - site 3 is clock
  - sites 4..4+W-1 are data bits 0..W-1
  - sites 4+W..4+2W-1 are count output bits 0..W-1
  With W=4 this gives 24 valid codes, 0..23.
- R4: A valid code forces only its site to its polarity. A code of 24 or higher injects no fault, so both copies match and the fault is never detected.
- R5: A fault on the clock site, of either polarity, stops the faulty copy from updating on any step. An active clear still zeroes that copy.
- R6: Before every fault trial, both copies are reset to zero. The trial then spends PAT_LEN steps, and `step_o` presents the indices 0..PAT_LEN-1 once each, in order.
- R7: A fault is counted as detected when the two copies' count outputs differ in at least one step of its trial. Each trial adds at most 1 to `detected_o`.
- R8: In sweep mode (`single_i`=0), the codes 0..23 are tried in ascending order, and the run ends with `total_o`=24.
- R9: In single mode (`single_i`=1), only `fault_sel_i` is tried, and the run ends with `total_o`=1.
- R10: After a run, `done_o` stays high and both counters hold until the next start. A start clears both counters and raises `busy_o` on the following cycle.
- R11: After reset, `busy_o`, `done_o`, `detected_o` and `total_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a run (accepted when idle or done) |
| single_i | input | 1 | 1: try only `fault_sel_i`; 0: sweep all faults |
| fault_sel_i | input | 5 | Fault code for single mode |
| stim_load_i | input | 1 | Stimulus load for the current step |
| stim_up_i | input | 1 | Stimulus direction for the current step |
| stim_clr_n_i | input | 1 | Stimulus active-low clear for the current step |
| stim_data_i | input | CW_P+1 | Stimulus load data for the current step |
| step_o | output | $clog2(PAT_LEN) | Index of the step whose stimulus is requested |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The last run has finished |
| detected_o | output | 5 | Faults detected in the last run |
| total_o | output | 5 | Faults tried in the last run |

## Verification
The bench uses two stimulus sequences.

- A rich sequence that loads, counts both ways and clears mid-run. It separates faults that alter counting from faults that are masked by clearing.
- An all-clear sequence that holds the counter at zero. It detects only faults that break clearing or force an output bit high, which exposes any site that is decoded or forced wrongly.

Each sequence is run as a full sweep, and then every one of the 32 codes is run in single mode, including the invalid codes. The bench checks each result against a per-code model built from the site table.

// File: rtl/fcov_pkg.sv
package fcov_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLUSH = 2'd1,
        ST_STEP  = 2'd2,
        ST_DONE  = 2'd3
    } run_state_e;

    // fixed site numbers for the control pins
    localparam int SITE_LOAD  = 0;
    localparam int SITE_UP    = 1;
    localparam int SITE_CLEAR = 2;
    localparam int SITE_CLOCK = 3;
    localparam int SITE_CTL_N = 4;

endpackage

// File: rtl/fault_site.sv
module fault_site #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] force_i,
    input  logic         stuck_i,
    output logic [W-1:0] y_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y_o[i] = force_i[i] ? stuck_i : a_i[i];
    end
endmodule

// File: rtl/cut_counter.sv
module cut_counter #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          act_i,
    input  logic          ck_en_i,
    input  logic          clr_n_i,
    input  logic          load_i,
    input  logic          up_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] q_o
);
    logic [DW-1:0] cnt_d, cnt_q;
    logic          clr_now;

    assign clr_now = act_i && !clr_n_i;

    always_comb begin
        cnt_d = cnt_q;
        if (flush_i) begin
            cnt_d = '0;
        end else if (clr_now) begin
            cnt_d = '0;
        end else if (act_i && ck_en_i) begin
            if (load_i)    cnt_d = din_i;
            else if (up_i) cnt_d = cnt_q + DW'(1);
            else           cnt_d = cnt_q - DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // clear reaches the output in the same step, as an asynchronous clear would
    assign q_o = clr_now ? '0 : cnt_q;
endmodule

// File: rtl/fault_cov_engine.sv
module fault_cov_engine #(
    parameter int CW_P    = 3,
    parameter int PAT_LEN = 16,
    localparam int DW     = CW_P + 1,
    localparam int NSITE  = fcov_pkg::SITE_CTL_N + 2 * DW,
    localparam int NFLT   = 2 * NSITE,
    localparam int CODE_W = $clog2(NFLT),
    localparam int STEP_W = $clog2(PAT_LEN),
    localparam int CNT_W  = $clog2(NFLT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              single_i,
    input  logic [CODE_W-1:0] fault_sel_i,
    input  logic              stim_load_i,
    input  logic              stim_up_i,
    input  logic              stim_clr_n_i,
    input  logic [DW-1:0]     stim_data_i,
    output logic [STEP_W-1:0] step_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  detected_o,
    output logic [CNT_W-1:0]  total_o
);
    import fcov_pkg::*;

    localparam int SITE_W   = CODE_W - 1;
    localparam int SITE_DIN = SITE_CTL_N;
    localparam int SITE_Q   = SITE_CTL_N + DW;

    typedef struct packed {
        run_state_e        state;
        logic [CODE_W-1:0] fault;
        logic [STEP_W-1:0] step;
        logic              mm;
        logic              single;
        logic [CNT_W-1:0]  det;
        logic [CNT_W-1:0]  tot;
    } eng_t;

    eng_t r_q, r_d;

    // ---------------- fault decode ----------------
    logic              f_valid;
    logic [SITE_W-1:0] f_site;
    logic              f_pol;
    logic [2:0]        ctl_force;
    logic              clk_force;
    logic [DW-1:0]     din_force;
    logic [DW-1:0]     q_force;

    assign f_valid = r_q.fault < CODE_W'(NFLT);
    assign f_site  = r_q.fault[CODE_W-1:1];
    assign f_pol   = r_q.fault[0];

    assign ctl_force[0] = f_valid && (f_site == SITE_W'(SITE_LOAD));
    assign ctl_force[1] = f_valid && (f_site == SITE_W'(SITE_UP));
    assign ctl_force[2] = f_valid && (f_site == SITE_W'(SITE_CLEAR));
    assign clk_force    = f_valid && (f_site == SITE_W'(SITE_CLOCK));

    for (genvar i = 0; i < DW; i++) begin : g_dec
        assign din_force[i] = f_valid && (f_site == SITE_W'(SITE_DIN + i));
        assign q_force[i]   = f_valid && (f_site == SITE_W'(SITE_Q + i));
    end

    // ---------------- copies under test ----------------
    logic          run_act, run_flush;
    logic [2:0]    ctl_raw, ctl_f;
    logic [DW-1:0] din_f, q_gold, q_raw, q_fault;
    logic          out_diff;

    assign run_act   = (r_q.state == ST_STEP);
    assign run_flush = (r_q.state == ST_FLUSH);
    assign ctl_raw   = {stim_clr_n_i, stim_up_i, stim_load_i};

    fault_site #(.W(3)) u_site_ctl (
        .a_i(ctl_raw), .force_i(ctl_force), .stuck_i(f_pol), .y_o(ctl_f)
    );

    fault_site #(.W(DW)) u_site_din (
        .a_i(stim_data_i), .force_i(din_force), .stuck_i(f_pol), .y_o(din_f)
    );

    cut_counter #(.DW(DW)) u_gold (
        .clk(clk), .rst_n(rst_n), .flush_i(run_flush), .act_i(run_act),
        .ck_en_i(1'b1), .clr_n_i(stim_clr_n_i), .load_i(stim_load_i),
        .up_i(stim_up_i), .din_i(stim_data_i), .q_o(q_gold)
    );

    // a stuck clock, at either level, never produces an edge
    cut_counter #(.DW(DW)) u_faulty (
        .clk(clk), .rst_n(rst_n), .flush_i(run_flush), .act_i(run_act),
        .ck_en_i(!clk_force), .clr_n_i(ctl_f[2]), .load_i(ctl_f[0]),
        .up_i(ctl_f[1]), .din_i(din_f), .q_o(q_raw)
    );

    fault_site #(.W(DW)) u_site_q (
        .a_i(q_raw), .force_i(q_force), .stuck_i(f_pol), .y_o(q_fault)
    );

    assign out_diff = run_act && (q_gold != q_fault);

    // ---------------- run sequencer ----------------
    logic hit;
    assign hit = r_q.mm || out_diff;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    r_d.state  = ST_FLUSH;
                    r_d.single = single_i;
                    r_d.fault  = single_i ? fault_sel_i : '0;
                    r_d.det    = '0;
                    r_d.tot    = '0;
                    r_d.step   = '0;
                end
            end
            ST_FLUSH: begin
                r_d.mm    = 1'b0;
                r_d.step  = '0;
                r_d.state = ST_STEP;
            end
            ST_STEP: begin
                r_d.mm = hit;
                if (r_q.step == STEP_W'(PAT_LEN - 1)) begin
                    r_d.tot  = r_q.tot + CNT_W'(1);
                    r_d.det  = r_q.det + CNT_W'(hit);
                    r_d.step = '0;
                    if (r_q.single || r_q.fault == CODE_W'(NFLT - 1)) begin
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.fault = r_q.fault + CODE_W'(1);
                        r_d.state = ST_FLUSH;
                    end
                end else begin
                    r_d.step = r_q.step + STEP_W'(1);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, fault: '0, step: '0, mm: 1'b0,
                     single: 1'b0, det: '0, tot: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign step_o     = r_q.step;
    assign busy_o     = run_act || run_flush;
    assign done_o     = (r_q.state == ST_DONE);
    assign detected_o = r_q.det;
    assign total_o    = r_q.tot;
endmodule

// File: rtl/fce_checker.sv
module fce_checker #(
    parameter int CW_P    = 3,
    parameter int PAT_LEN = 16,
    localparam int DW     = CW_P + 1,
    localparam int NFLT   = 2 * (4 + 2 * DW),
    localparam int STEP_W = $clog2(PAT_LEN),
    localparam int CNT_W  = $clog2(NFLT + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [STEP_W-1:0] step_o,
    input logic [CNT_W-1:0]  detected_o,
    input logic [CNT_W-1:0]  total_o
);
    assert_det_le_tot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        detected_o <= total_o);

    assert_tot_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        total_o <= CNT_W'(NFLT));

    assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    assert_step_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o != '0) |-> busy_o);

    assert_det_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (detected_o != $past(detected_o)) |->
            (detected_o == $past(detected_o) + CNT_W'(1)) || (detected_o == '0));

    assert_tot_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (total_o != $past(total_o)) |->
            (total_o == $past(total_o) + CNT_W'(1)) || (total_o == '0));

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(total_o) && $stable(detected_o) && done_o));
endmodule

bind fault_cov_engine fce_checker #(.CW_P(CW_P), .PAT_LEN(PAT_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .step_o(step_o), .detected_o(detected_o), .total_o(total_o)
);

// File: tb/sim_fault_cov_engine.sv
`timescale 1ns/1ps
module sim_fault_cov_engine;
    localparam int PL = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       single_i = 1'b0;
    logic [4:0] fault_sel_i = '0;
    logic       stim_load_i = 1'b0, stim_up_i = 1'b0, stim_clr_n_i = 1'b1;
    logic [3:0] stim_data_i = '0;   // R2: 4-bit data with default CW_P=3
    logic [3:0] step_o;
    logic       busy_o, done_o;
    logic [4:0] detected_o, total_o;

    int n_chk = 0, n_bad = 0, pat_sel = 0, n_last = 0, cyc = 0;

    always #10 clk = ~clk;   // 50 MHz

    fault_cov_engine #(.CW_P(3), .PAT_LEN(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .single_i(single_i),
        .fault_sel_i(fault_sel_i), .stim_load_i(stim_load_i),
        .stim_up_i(stim_up_i), .stim_clr_n_i(stim_clr_n_i),
        .stim_data_i(stim_data_i), .step_o(step_o), .busy_o(busy_o),
        .done_o(done_o), .detected_o(detected_o), .total_o(total_o)
    );

    // returns {clr_n, up, load, data[3:0]}
    function automatic logic [6:0] stim(int k, int pat);
        logic c, u, l;
        logic [3:0] d;
        if (pat == 0) begin
            c = (k != 9);
            l = (k == 2) || (k == 12);
            u = (k < 7) || (k > 12);
            d = (k == 2) ? 4'b1010 : 4'b0101;
        end else begin
            c = 1'b0; l = 1'b0; u = 1'b0; d = 4'b0000;
        end
        return {c, u, l, d};
    endfunction

    // per-fault expectation from the site table (R1, R3, R4, R5, R7)
    function automatic bit model_hit(int code, int pat);
        bit valid, pol, hit, fck, clrn, up, ld, fclrn, fup, fld;
        int site;
        logic [3:0] g, f, d, fd, go, fo;
        logic [6:0] s;
        valid = (code < 24);
        site  = code >> 1;
        pol   = code[0];
        hit   = 0;
        g = '0; f = '0;
        fck = !(valid && site == 3);
        for (int k = 0; k < PL; k++) begin
            s = stim(k, pat);
            clrn = s[6]; up = s[5]; ld = s[4]; d = s[3:0];
            fclrn = (valid && site == 2) ? pol : clrn;
            fup   = (valid && site == 1) ? pol : up;
            fld   = (valid && site == 0) ? pol : ld;
            fd = d;
            for (int b = 0; b < 4; b++) if (valid && site == 4 + b) fd[b] = pol;
            go = clrn ? g : 4'd0;
            fo = fclrn ? f : 4'd0;
            for (int b = 0; b < 4; b++) if (valid && site == 8 + b) fo[b] = pol;
            if (go != fo) hit = 1;
            if (!clrn) g = '0;
            else if (ld) g = d;
            else if (up) g = g + 4'd1;
            else g = g - 4'd1;
            if (!fclrn) f = '0;
            else if (fck) begin
                if (fld) f = fd;
                else if (fup) f = f + 4'd1;
                else f = f - 4'd1;
            end
        end
        return hit;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // stimulus follows the requested step index
    initial begin
        logic [6:0] s;
        forever begin
            @(negedge clk);
            s = stim(int'(step_o), pat_sel);
            {stim_clr_n_i, stim_up_i, stim_load_i, stim_data_i} = s;
            if (busy_o && step_o == 4'(PL - 1)) n_last++;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
                finish_up();
            end
        end
    end

    task automatic run(bit single, int code, int pat);
        int w;
        @(negedge clk);
        pat_sel = pat; single_i = single; fault_sel_i = 5'(code); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R10 start clears total", int'(total_o), 0);
        check("R10 busy after start", int'(busy_o), 1);
        w = 0;
        while (!done_o && w < 2000) begin @(negedge clk); w++; end
    endtask

    initial begin
        int exp_det, last0;
        repeat (3) @(negedge clk);
        check("R11 reset busy", int'(busy_o), 0);
        check("R11 reset done", int'(done_o), 0);
        check("R11 reset detected", int'(detected_o), 0);
        check("R11 reset total", int'(total_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int p = 0; p < 2; p++) begin
            // R8 sweep, R1 counter behaviour through coverage
            exp_det = 0;
            for (int c = 0; c < 24; c++) exp_det += int'(model_hit(c, p));
            last0 = n_last;
            run(1'b0, 0, p);
            check("R8 sweep total", int'(total_o), 24);
            check("R1 R7 sweep detected", int'(detected_o), exp_det);
            check("R10 done after sweep", int'(done_o), 1);
            check("R6 one final step per trial", n_last - last0, 24);
            repeat (5) @(negedge clk);
            check("R10 hold detected", int'(detected_o), exp_det);
            check("R10 hold total", int'(total_o), 24);

            // R9 single mode, every code incl. invalid (R4)
            for (int c = 0; c < 32; c++) begin
                run(1'b1, c, p);
                check("R9 single total", int'(total_o), 1);
                if (c >= 24)
                    check("R4 invalid code no fault", int'(detected_o), 0);
                else if (c == 6 || c == 7)
                    check("R5 clock site", int'(detected_o), int'(model_hit(c, p)));
                else
                    check("R3 R7 single detected", int'(detected_o), int'(model_hit(c, p)));
            end
        end
        // R5: with the rich sequence a frozen copy must be seen
        check("R5 clock stuck-0 detected", int'(model_hit(6, 0)), 1);
        finish_up();
    end
endmodule